// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store with Phase Mirroring

This block holds the filter coefficients of a 64-phase polyphase scaler. It keeps four independent filter sets, selected by a 2-bit filter kind: 0 is luma vertical, 1 is chroma vertical, 2 is luma horizontal and 3 is chroma horizontal. Because the phase response of a symmetric filter mirrors about the half-way phase, only phases 0 through 32 are stored. A read of phase p above 32 is served from stored phase 64-p with the tap order reversed.

Software loads coefficients through two register strobes. A select strobe latches the filter kind, the phase and the tap-pair index. A data strobe then writes an even-tap and an odd-tap coefficient, and each half has its own enable. All writes land in a shadow bank. Setting an update request swaps the shadow and active banks at the next frame-start pulse.

The memory is power gated. Software raises a power-disable input and waits for the gated status to read 0 before it writes. A data write made while the memory is still gated is dropped, and a sticky error flag is raised. The scaler reads a coefficient by filter kind, phase, tap and tap-count code. The value arrives two clock edges later.

Top module: `polyphase_coef_ram`

## Requirements
- R1: After synchronous reset, pwr_state is 1, upd_pending is 0, active_bank is 0, wr_err is 0 and rd_valid is 0.
- R2: pwr_state reads 0 once pwr_dis has been sampled high on WAKE_CYCLES (default 4) consecutive edges. It returns to 1 on the edge after pwr_dis is sampled low.
- R3: A data strobe sampled while pwr_state is 1 writes nothing, and it sets wr_err, which stays set until reset.
- R4: Data writes go only to the shadow bank (the one not indicated by active_bank), so reads do not see them until a bank swap.
- R5: upd_set sets upd_pending. On a frame_start edge with upd_pending already set, active_bank toggles and upd_pending clears. A frame_start without a pending request changes nothing. When upd_set and frame_start coincide with no request pending, the request is only armed.
- R6: A data strobe writes the even coefficient only if even_en is 1 and the odd coefficient only if odd_en is 1. A disabled half keeps its previous value.
- R7: A read sampled with rd_en gives rd_valid and rd_data two clock edges later. For phases 0 to 32, tap t comes from tap-pair t/2, from the even half when t is even and from the odd half when t is odd.
- R8: For a read phase p from 33 to 63, the data is the stored coefficient at phase 64-p and tap (rd_ntaps_m1 - t).
- R9: rd_ntaps_m1 holds the tap count minus one: code 0 means 1 tap, 1 means 2 taps and 3 means 4 taps. A read returns 0 for code 0 (a single tap uses no coefficient), for code 2, or when the tap exceeds the code.
- R10: A data strobe whose latched phase is above 32 is ignored and disturbs no stored coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dis | input | 1 | Request to lift memory power gating |
| pwr_state | output | 1 | 1 while the memory is gated, 0 when writable |
| sel_we | input | 1 | Latch the select fields |
| sel_type | input | 2 | Filter kind (0 luma V, 1 chroma V, 2 luma H, 3 chroma H) |
| sel_phase | input | 6 | Phase to be written |
| sel_pair | input | 1 | Tap-pair index to be written |
| dat_we | input | 1 | Data strobe for the latched location |
| even_en | input | 1 | Write enable for the even half |
| even_coef | input | 16 | Even-tap coefficient |
| odd_en | input | 1 | Write enable for the odd half |
| odd_coef | input | 16 | Odd-tap coefficient |
| wr_err | output | 1 | Sticky: a data write was attempted while gated |
| upd_set | input | 1 | Request a bank swap |
| frame_start | input | 1 | Frame boundary pulse |
| upd_pending | output | 1 | Swap request armed |
| active_bank | output | 1 | Bank currently used for reads |
| rd_en | input | 1 | Read request |
| rd_type | input | 2 | Filter kind to read |
| rd_phase | input | 6 | Phase to read, 0 to 63 |
| rd_tap | input | 2 | Tap to read |
| rd_ntaps_m1 | input | 2 | Tap count minus one |
| rd_data | output | 16 | Coefficient read |
| rd_valid | output | 1 | rd_data is valid |

## Verification
The bench builds the block with its defaults: 64 phases, up to 4 taps, 16-bit coefficients and a 4-cycle wake delay. The short wake delay allows the check at the exact edge where the gated status drops. Every stored phase of every filter kind is loaded, so reads can reach both boundary phases 0 and 32 and the mirrored extremes 33 and 63 under 2-tap and 4-tap codes. An out-of-range phase 40 write is aimed where an unchecked address would alias onto another filter kind's phase 7, which makes a missing range guard visible at the read port.

// File: rtl/coef_ram_pkg.sv
package coef_ram_pkg;
  localparam int NTYPES = 4;

  typedef enum logic [1:0] {
    FK_LUMA_V   = 2'd0,
    FK_CHROMA_V = 2'd1,
    FK_LUMA_H   = 2'd2,
    FK_CHROMA_H = 2'd3
  } filt_kind_e;
endpackage

// File: rtl/coef_pwr_seq.sv
module coef_pwr_seq #(
  parameter int WAKE_CYCLES = 4,
  localparam int CW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_dis,
  output logic pwr_state
);
  localparam logic [CW-1:0] WAKE = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (!pwr_dis)  cnt <= '0;
    else if (cnt != WAKE) cnt <= cnt + 1'b1;
  end

  // gated until the wake counter has saturated
  assign pwr_state = (cnt != WAKE);
endmodule

// File: rtl/coef_bank_ctl.sv
module coef_bank_ctl (
  input  logic clk,
  input  logic rst,
  input  logic upd_set,
  input  logic frame_start,
  output logic upd_pending,
  output logic active_bank
);
  logic swap;
  assign swap = upd_pending && frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_pending <= 1'b0;
      active_bank <= 1'b0;
    end else begin
      upd_pending <= upd_set || (upd_pending && !frame_start);
      if (swap) active_bank <= ~active_bank;
    end
  end
endmodule

// File: rtl/coef_mirror_map.sv
module coef_mirror_map #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  localparam int PH_W   = $clog2(NUM_PHASES),
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int PAIR_W = TAP_W - 1
) (
  input  logic [PH_W-1:0]   phase,
  input  logic [TAP_W-1:0]  tap,
  input  logic [TAP_W-1:0]  ntaps_m1,
  output logic [PH_W-1:0]   st_phase,
  output logic [PAIR_W-1:0] st_pair,
  output logic              st_odd,
  output logic              zero
);
  localparam int HALF = NUM_PHASES / 2;

  logic [TAP_W:0]   cnt_x;
  logic             mirrored;
  logic [TAP_W-1:0] st_tap;
  logic [PH_W:0]    refl;

  always_comb begin
    cnt_x    = {1'b0, ntaps_m1} + 1'b1;
    // no coefficient for one tap, unsupported counts or taps beyond the count
    zero     = (ntaps_m1 == '0) ||
               ((cnt_x & {1'b0, ntaps_m1}) != '0) ||
               (tap > ntaps_m1);
    mirrored = (int'(phase) > HALF);
    refl     = (PH_W+1)'(NUM_PHASES) - {1'b0, phase};
    st_phase = mirrored ? refl[PH_W-1:0] : phase;
    st_tap   = mirrored ? (ntaps_m1 - tap) : tap;
    st_pair  = st_tap[TAP_W-1:1];
    st_odd   = st_tap[0];
  end
endmodule

// File: rtl/coef_store.sv
module coef_store
  import coef_ram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  localparam int PH_W   = $clog2(NUM_PHASES),
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int PAIR_W = TAP_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  // select register
  input  logic              sel_we,
  input  logic [1:0]        sel_type,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [PAIR_W-1:0] sel_pair,
  // data write, already qualified by power state
  input  logic              dat_ok,
  input  logic              even_en,
  input  logic [COEF_W-1:0] even_coef,
  input  logic              odd_en,
  input  logic [COEF_W-1:0] odd_coef,
  input  logic              wr_bank,
  // read, already mapped to stored location
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [1:0]        rd_type,
  input  logic [PH_W-1:0]   rd_sphase,
  input  logic [PAIR_W-1:0] rd_pair,
  input  logic              rd_odd,
  input  logic              rd_zero,
  output logic [COEF_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HALF   = NUM_PHASES / 2;
  localparam int STORED = HALF + 1;
  localparam int PAIRS  = MAX_TAPS / 2;
  localparam int DEPTH  = 2 * NTYPES * STORED * PAIRS;
  localparam int AW     = $clog2(DEPTH);

  logic [COEF_W-1:0] even_mem [DEPTH];
  logic [COEF_W-1:0] odd_mem  [DEPTH];

  filt_kind_e        sel_kind_q;
  logic [PH_W-1:0]   sel_phase_q;
  logic [PAIR_W-1:0] sel_pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_kind_q  <= FK_LUMA_V;
      sel_phase_q <= '0;
      sel_pair_q  <= '0;
    end else if (sel_we) begin
      sel_kind_q  <= filt_kind_e'(sel_type);
      sel_phase_q <= sel_phase;
      sel_pair_q  <= sel_pair;
    end
  end

  function automatic logic [AW-1:0] loc(input logic bank, input logic [1:0] kind,
                                        input logic [PH_W-1:0] ph,
                                        input logic [PAIR_W-1:0] pr);
    int idx;
    idx = ((int'(bank) * NTYPES + int'(kind)) * STORED + int'(ph)) * PAIRS + int'(pr);
    return AW'(idx);
  endfunction

  logic            ph_ok;
  logic [AW-1:0]   waddr, raddr;
  logic            we_even, we_odd;

  always_comb begin
    ph_ok   = (int'(sel_phase_q) <= HALF);
    waddr   = loc(wr_bank, sel_kind_q, ph_ok ? sel_phase_q : '0, sel_pair_q);
    we_even = dat_ok && ph_ok && even_en;
    we_odd  = dat_ok && ph_ok && odd_en;
    raddr   = loc(rd_bank, rd_type, rd_sphase, rd_pair);
  end

  // two simple dual-port memories, one per tap half
  always_ff @(posedge clk) begin
    if (we_even) even_mem[waddr] <= even_coef;
  end

  always_ff @(posedge clk) begin
    if (we_odd) odd_mem[waddr] <= odd_coef;
  end

  logic [COEF_W-1:0] even_q, odd_q;
  logic              odd_q1, zero_q1, vld_q1;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      even_q <= even_mem[raddr];
      odd_q  <= odd_mem[raddr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q1   <= 1'b0;
      zero_q1  <= 1'b1;
      vld_q1   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      vld_q1   <= rd_en;
      if (rd_en) begin
        odd_q1  <= rd_odd;
        zero_q1 <= rd_zero;
      end
      rd_valid <= vld_q1;
      if (vld_q1) rd_data <= zero_q1 ? '0 : (odd_q1 ? odd_q : even_q);
    end
  end
endmodule

// File: rtl/polyphase_coef_ram.sv
module polyphase_coef_ram #(
  parameter int COEF_W      = 16,
  parameter int NUM_PHASES  = 64,
  parameter int MAX_TAPS    = 4,
  parameter int WAKE_CYCLES = 4,
  localparam int PH_W   = $clog2(NUM_PHASES),
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int PAIR_W = TAP_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dis,
  output logic              pwr_state,
  input  logic              sel_we,
  input  logic [1:0]        sel_type,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [PAIR_W-1:0] sel_pair,
  input  logic              dat_we,
  input  logic              even_en,
  input  logic [COEF_W-1:0] even_coef,
  input  logic              odd_en,
  input  logic [COEF_W-1:0] odd_coef,
  output logic              wr_err,
  input  logic              upd_set,
  input  logic              frame_start,
  output logic              upd_pending,
  output logic              active_bank,
  input  logic              rd_en,
  input  logic [1:0]        rd_type,
  input  logic [PH_W-1:0]   rd_phase,
  input  logic [TAP_W-1:0]  rd_tap,
  input  logic [TAP_W-1:0]  rd_ntaps_m1,
  output logic [COEF_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              dat_ok;
  logic [PH_W-1:0]   m_phase;
  logic [PAIR_W-1:0] m_pair;
  logic              m_odd, m_zero;

  coef_pwr_seq #(.WAKE_CYCLES(WAKE_CYCLES)) i_pwr (
    .clk(clk), .rst(rst), .pwr_dis(pwr_dis), .pwr_state(pwr_state)
  );

  coef_bank_ctl i_bank (
    .clk(clk), .rst(rst), .upd_set(upd_set), .frame_start(frame_start),
    .upd_pending(upd_pending), .active_bank(active_bank)
  );

  assign dat_ok = dat_we && !pwr_state;

  always_ff @(posedge clk) begin
    if (rst)                       wr_err <= 1'b0;
    else if (dat_we && pwr_state)  wr_err <= 1'b1;
  end

  coef_mirror_map #(.NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS)) i_map (
    .phase(rd_phase), .tap(rd_tap), .ntaps_m1(rd_ntaps_m1),
    .st_phase(m_phase), .st_pair(m_pair), .st_odd(m_odd), .zero(m_zero)
  );

  coef_store #(.COEF_W(COEF_W), .NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS)) i_store (
    .clk(clk), .rst(rst),
    .sel_we(sel_we), .sel_type(sel_type), .sel_phase(sel_phase), .sel_pair(sel_pair),
    .dat_ok(dat_ok), .even_en(even_en), .even_coef(even_coef),
    .odd_en(odd_en), .odd_coef(odd_coef), .wr_bank(~active_bank),
    .rd_en(rd_en), .rd_bank(active_bank), .rd_type(rd_type),
    .rd_sphase(m_phase), .rd_pair(m_pair), .rd_odd(m_odd), .rd_zero(m_zero),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/polyphase_coef_ram_chk.sv
module polyphase_coef_ram_chk #(
  parameter int COEF_W = 16,
  parameter int TAP_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_dis,
  input logic              pwr_state,
  input logic              dat_we,
  input logic              wr_err,
  input logic              upd_set,
  input logic              frame_start,
  input logic              upd_pending,
  input logic              active_bank,
  input logic              rd_en,
  input logic [TAP_W-1:0]  rd_ntaps_m1,
  input logic [COEF_W-1:0] rd_data,
  input logic              rd_valid
);
  // R1: state right after a reset edge
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pwr_state && !upd_pending && !active_bank && !wr_err && !rd_valid));

  // R2: gating returns as soon as the request is dropped
  p_regate_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_dis |=> pwr_state);

  // R3: gated write raises the flag, which then sticks
  p_gated_err_r3: assert property (@(posedge clk) disable iff (rst)
    (dat_we && pwr_state) |=> wr_err);
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R5: request arming and swap timing
  p_arm_r5: assert property (@(posedge clk) disable iff (rst)
    upd_set |=> upd_pending);
  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_pending && frame_start) |=> (active_bank != $past(active_bank)));
  p_hold_bank_r5: assert property (@(posedge clk) disable iff (rst)
    !(upd_pending && frame_start) |=> $stable(active_bank));

  // R7: two-edge read latency
  p_rd_latency_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rd_valid);

  // R9: single-tap code reads zero
  p_one_tap_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_ntaps_m1 == '0) |-> ##2 (rd_data == '0));
endmodule

bind polyphase_coef_ram polyphase_coef_ram_chk #(.COEF_W(COEF_W), .TAP_W(TAP_W)) i_chk (.*);

// File: tb/test_polyphase_coef_ram.sv
module test_polyphase_coef_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_dis = 1'b0, pwr_state;
  logic        sel_we = 1'b0;
  logic [1:0]  sel_type = '0;
  logic [5:0]  sel_phase = '0;
  logic [0:0]  sel_pair = '0;
  logic        dat_we = 1'b0, even_en = 1'b0, odd_en = 1'b0;
  logic [15:0] even_coef = '0, odd_coef = '0;
  logic        wr_err, upd_set = 1'b0, frame_start = 1'b0, upd_pending, active_bank;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_type = '0, rd_tap = '0, rd_ntaps_m1 = '0;
  logic [5:0]  rd_phase = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  polyphase_coef_ram i_polyphase_coef_ram (.*);

  // table fields: kind[11:10] phase[9:4] tap[3:2] ntaps_m1[1:0]
  localparam int NV = 16;
  localparam logic [11:0] TBL [NV] = '{
    {2'd0, 6'd0,  2'd0, 2'd3}, {2'd0, 6'd0,  2'd3, 2'd3},
    {2'd1, 6'd32, 2'd2, 2'd3}, {2'd2, 6'd17, 2'd1, 2'd3},
    {2'd3, 6'd33, 2'd0, 2'd3}, {2'd3, 6'd63, 2'd3, 2'd3},
    {2'd1, 6'd48, 2'd1, 2'd1}, {2'd2, 6'd40, 2'd2, 2'd3},
    {2'd0, 6'd20, 2'd1, 2'd0}, {2'd0, 6'd20, 2'd1, 2'd2},
    {2'd1, 6'd10, 2'd3, 2'd1}, {2'd2, 6'd2,  2'd1, 2'd1},
    {2'd3, 6'd50, 2'd2, 2'd3}, {2'd0, 6'd31, 2'd3, 2'd3},
    {2'd1, 6'd7,  2'd0, 2'd3}, {2'd1, 6'd57, 2'd3, 2'd3}
  };

  function automatic logic [15:0] pat(input int k, input int p, input int t);
    logic [1:0] kk; logic [5:0] pp; logic [1:0] tt;
    kk = k[1:0]; pp = p[5:0]; tt = t[1:0];
    return {kk, pp, tt, 6'b101101};
  endfunction

  // read model built from R7, R8 and R9
  function automatic logic [15:0] model(input int k, input int p, input int t, input int nm1);
    if (nm1 == 0 || nm1 == 2 || t > nm1) return 16'h0;
    if (p <= 32) return pat(k, p, t);
    return pat(k, 64 - p, nm1 - t);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_pair(input int k, input int p, input int pr,
                         input bit een, input logic [15:0] ev,
                         input bit oen, input logic [15:0] od);
    @(negedge clk);
    sel_we = 1'b1; sel_type = k[1:0]; sel_phase = p[5:0]; sel_pair = pr[0:0];
    @(negedge clk);
    sel_we = 1'b0; dat_we = 1'b1;
    even_en = een; even_coef = ev; odd_en = oen; odd_coef = od;
    @(negedge clk);
    dat_we = 1'b0; even_en = 1'b0; odd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int k, input int p, input int t,
                        input int nm1, input logic [15:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_type = k[1:0]; rd_phase = p[5:0]; rd_tap = t[1:0]; rd_ntaps_m1 = nm1[1:0];
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 valid not early", {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    check("R7 valid", {31'd0, rd_valid}, 32'd1);
    check(req, {16'd0, rd_data}, {16'd0, exp});
  endtask

  task automatic pulse_upd(input bit with_frame);
    @(negedge clk); upd_set = 1'b1; frame_start = with_frame;
    @(negedge clk); upd_set = 1'b0; frame_start = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check("R1 pwr_state", {31'd0, pwr_state}, 32'd1);
    check("R1 upd_pending", {31'd0, upd_pending}, 32'd0);
    check("R1 active_bank", {31'd0, active_bank}, 32'd0);
    check("R1 wr_err", {31'd0, wr_err}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);

    // R2: wake after exactly 4 sampled edges
    pwr_dis = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) check("R2 still gated", {31'd0, pwr_state}, 32'd1);
    @(negedge clk) check("R2 awake", {31'd0, pwr_state}, 32'd0);

    // fill shadow bank 1 with the pattern
    for (int k = 0; k < 4; k++)
      for (int p = 0; p <= 32; p++)
        for (int pr = 0; pr < 2; pr++)
          wr_pair(k, p, pr, 1'b1, pat(k, p, 2*pr), 1'b1, pat(k, p, 2*pr+1));

    pulse_frame();
    check("R5 frame without request", {31'd0, active_bank}, 32'd0);

    // R2/R3: regate, then a dropped write
    @(negedge clk) pwr_dis = 1'b0;
    @(negedge clk) check("R2 regated", {31'd0, pwr_state}, 32'd1);
    wr_pair(0, 1, 0, 1'b1, 16'hDEAD, 1'b1, 16'hBEEF);
    check("R3 wr_err set", {31'd0, wr_err}, 32'd1);
    pwr_dis = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 awake again", {31'd0, pwr_state}, 32'd0);

    pulse_upd(1'b0);
    check("R5 pending armed", {31'd0, upd_pending}, 32'd1);
    check("R5 no swap yet", {31'd0, active_bank}, 32'd0);
    pulse_frame();
    check("R5 swapped", {31'd0, active_bank}, 32'd1);
    check("R5 pending cleared", {31'd0, upd_pending}, 32'd0);
    rd_chk("R3 gated write dropped", 0, 1, 0, 3, pat(0, 1, 0));
    check("R3 wr_err sticky", {31'd0, wr_err}, 32'd1);

    // R6 and R4: partial writes into shadow bank 0
    wr_pair(2, 7, 1, 1'b1, 16'h1111, 1'b1, 16'h2222);
    wr_pair(2, 7, 1, 1'b0, 16'h3333, 1'b1, 16'h4444);
    rd_chk("R4 shadow write invisible", 2, 7, 2, 3, pat(2, 7, 2));
    pulse_upd(1'b0);
    pulse_frame();
    check("R5 swapped back", {31'd0, active_bank}, 32'd0);
    rd_chk("R6 even half kept", 2, 7, 2, 3, 16'h1111);
    rd_chk("R6 odd half written", 2, 7, 3, 3, 16'h4444);

    // R10: phase 40 write into bank 1 must not alias
    wr_pair(0, 40, 0, 1'b1, 16'h1234, 1'b1, 16'h5678);
    pulse_upd(1'b1);
    check("R5 coincident only arms", {31'd0, active_bank}, 32'd0);
    check("R5 coincident pending", {31'd0, upd_pending}, 32'd1);
    pulse_frame();
    check("R5 swapped third", {31'd0, active_bank}, 32'd1);
    rd_chk("R10 out-of-range phase ignored", 1, 7, 0, 3, pat(1, 7, 0));
    rd_chk("R10 out-of-range phase ignored", 1, 7, 1, 3, pat(1, 7, 1));

    // table walk: direct, mirrored and tap-count codes (R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      int k, p, t, nm1;
      k = int'(TBL[i][11:10]); p = int'(TBL[i][9:4]);
      t = int'(TBL[i][3:2]);   nm1 = int'(TBL[i][1:0]);
      rd_chk((p > 32) ? "R8 mirrored read" : ((nm1 == 0 || nm1 == 2 || t > nm1) ? "R9 zero read" : "R7 direct read"),
             k, p, t, nm1, model(k, p, t, nm1));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule